// File: doc/BRIEF.md
# Multi-Bank GPIO Interrupt Controller

This block gives software a register-mapped view of several banks of general-purpose pins. Each bank owns a 32-bit output-drive register and a set of per-pin interrupt controls: an interrupt enable mask, a latched event status, an edge polarity select, a both-edges override and a level-sensitive select. Every pin input is brought into the clock domain through a two-flop synchronizer. The synchronized value is then compared with its value from the previous cycle to find edges, or taken directly as a level.

A detected event sets the pin's status bit. The bit stays set until software writes a 1 to it. The enabled pending condition of every bank is merged into a single interrupt request. A separate wake request carries the same merged condition, for a power controller that watches it. A bank may be narrower than 32 pins: pins at or above the configured width never record events.

Register access uses a plain single-cycle write strobe and a read path with one cycle of latency. Each bank takes a 32-byte window in a byte address space.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Register address = bank index × 0x20 + offset. The offsets are: output drive 0x00, mask 0x04, status 0x08, edge polarity 0x0C, both-edges 0x10, level select 0x14. Read data for the address presented in one cycle appears in the next. Unused offsets and absent banks read as zero.
- R2: Bit i of bank b's output-drive register drives `pin_out[b*32+i]`, and the output changes in the cycle after the write.
- R3: When the level and both-edges bits are clear, a polarity bit of 1 records a rising edge and a polarity bit of 0 records a falling edge. An edge of the opposite direction is not recorded.
- R4: When a pin's both-edges bit is set, the pin records both rising and falling edges, whatever its polarity bit holds.
- R5: When a pin's level-select bit is set, the pin records an event in every cycle its synchronized input is high. A status bit cleared while the input stays high therefore sets again.
- R6: Writing the status register clears each bit written as 1. Bits written as 0 keep their value.
- R7: If a new event and a clear reach the same status bit in the same cycle, the bit stays set.
- R8: Pins at or above parameter `BANK_WIDTH` never set their status bit, in any mode.
- R9: The mask resets to zero. `irq_o` is a register that goes high one cycle after any bank has a status bit set together with its mask bit, and goes low one cycle after no bank has one.
- R10: `wake_o` follows the same masked condition as `irq_o`, on the same cycle.
- R11: A pin change driven before clock edge A sets status at edge A+2 and raises `irq_o` (if masked in) at edge A+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | ADDR_W | Byte address (bank window and register offset) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_in | input | NUM_BANKS*32 | Raw pin inputs, 32 per bank |
| pin_out | output | NUM_BANKS*32 | Output-drive register contents, 32 per bank |
| irq_o | output | 1 | Combined masked-status interrupt request |
| wake_o | output | 1 | Combined masked-status wake request |

## Verification
Two functions can act on one status bit in the same cycle: detecting a new event and the software clear. A level-sensitive pin held high makes every clear collide with an event, so the bench clears it and reads it back still set. Random pin toggling mixed with random status writes also lands edges in the same cycle as clears. A behavioural per-cycle model gives the new event priority, and every cycle the bench compares the read data and both request lines against that model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PINS_PER_BANK = 32;
  localparam int WINDOW_BYTES  = 32;

  typedef enum logic [2:0] {
    SEL_DRIVE = 3'd0,
    SEL_MASK  = 3'd1,
    SEL_STAT  = 3'd2,
    SEL_POL   = 3'd3,
    SEL_BOTH  = 3'd4,
    SEL_LEVEL = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      sync_out <= '0;
    end else begin
      stage1_q <= async_in;
      sync_out <= stage1_q;
    end
  end
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] both,
  input  logic [W-1:0] level,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= cur;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall;
    assign rise = cur[i] & ~prev_q[i];
    assign fall = ~cur[i] & prev_q[i];
    always_comb begin
      if (level[i])     evt[i] = cur[i];
      else if (both[i]) evt[i] = rise | fall;
      else if (pol[i])  evt[i] = rise;
      else              evt[i] = fall;
    end
  end

  // R3: with level and both-edges clear, a pin never fires on the opposite edge
  a_r3_no_wrong_edge: assert property (@(posedge clk) disable iff (rst)
    ((evt & ~level & ~both & pol & ~cur) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_irq_pkg::*;
#(
  parameter int ACTIVE = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  reg_sel_e    sel,
  input  logic [31:0] wdata,
  input  logic [31:0] pin_raw,
  output logic [31:0] drive_q,
  output logic [31:0] rd_val,
  output logic        pend
);
  localparam logic [31:0] VALID = 32'((64'h1 << ACTIVE) - 64'h1);

  logic [31:0] mask_q, stat_q, pol_q, both_q, level_q;
  logic [ACTIVE-1:0] cur, evt;
  logic [31:0] evt_full, clr;
  logic stat_wr;

  gpio_sync #(.W(ACTIVE)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_raw[ACTIVE-1:0]), .sync_out(cur)
  );

  gpio_event_detect #(.W(ACTIVE)) u_detect (
    .clk(clk), .rst(rst), .cur(cur),
    .pol(pol_q[ACTIVE-1:0]), .both(both_q[ACTIVE-1:0]),
    .level(level_q[ACTIVE-1:0]), .evt(evt)
  );

  if (ACTIVE < 32) begin : g_narrow
    logic unused_hi;
    assign unused_hi = ^{pin_raw[31:ACTIVE], pol_q[31:ACTIVE],
                         both_q[31:ACTIVE], level_q[31:ACTIVE]};
  end

  assign evt_full = 32'(evt);
  assign stat_wr  = wr_en && (sel == SEL_STAT);
  assign clr      = stat_wr ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= '0;
      mask_q  <= '0;
      pol_q   <= '0;
      both_q  <= '0;
      level_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DRIVE: drive_q <= wdata;
        SEL_MASK:  mask_q  <= wdata;
        SEL_POL:   pol_q   <= wdata;
        SEL_BOTH:  both_q  <= wdata;
        SEL_LEVEL: level_q <= wdata;
        default: ;
      endcase
    end
  end

  // new events take priority over a clear of the same bit
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr) | evt_full;
  end

  always_comb begin
    case (sel)
      SEL_DRIVE: rd_val = drive_q;
      SEL_MASK:  rd_val = mask_q;
      SEL_STAT:  rd_val = stat_q;
      SEL_POL:   rd_val = pol_q;
      SEL_BOTH:  rd_val = both_q;
      SEL_LEVEL: rd_val = level_q;
      default:   rd_val = '0;
    endcase
  end

  assign pend = |(stat_q & mask_q);

  // R6: a bit written 1 with no simultaneous event is clear afterwards
  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> ((stat_q & $past(wdata & ~evt_full)) == '0));
  // R7: any event leaves its status bit set, clear or not
  a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
    (|evt_full) |=> ((stat_q & $past(evt_full)) == $past(evt_full)));
  // R8: no status above the bank width
  a_r8_no_high_status: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~VALID) == '0));
  // R9: mask comes out of reset cleared
  a_r9_mask_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mask_q == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS  = 3,
  parameter int BANK_WIDTH = 24,
  localparam int BIDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W    = BIDX_W + $clog2(WINDOW_BYTES),
  localparam int PIN_W     = NUM_BANKS * PINS_PER_BANK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int OFS_W = $clog2(WINDOW_BYTES);

  logic [BIDX_W-1:0] bank_idx;
  reg_sel_e          sel;
  logic [31:0]       bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] pend_vec;
  logic [31:0]       rd_mux;
  logic              unused_addr;

  assign bank_idx    = reg_addr[ADDR_W-1:OFS_W];
  assign sel         = reg_sel_e'(reg_addr[OFS_W-1:2]);
  assign unused_addr = ^reg_addr[1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank #(.ACTIVE(BANK_WIDTH)) u_bank (
      .clk(clk), .rst(rst),
      .wr_en(reg_wr && (bank_idx == BIDX_W'(b))),
      .sel(sel), .wdata(reg_wdata),
      .pin_raw(pin_in[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .drive_q(pin_out[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .rd_val(bank_rd[b]),
      .pend(pend_vec[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_idx == BIDX_W'(b)) rd_mux = bank_rd[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
      wake_o    <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      irq_o     <= |pend_vec;
      wake_o    <= |pend_vec;
    end
  end

  // R9: the request is raised only after some bank had masked status pending
  a_r9_irq_from_pending: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|pend_vec));
  // R10: wake tracks the interrupt line cycle for cycle
  a_r10_wake_tracks_irq: assert property (@(posedge clk) disable iff (rst)
    (wake_o == irq_o));
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;
  localparam int NB = 3;
  localparam int W  = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [95:0] pin_in = '0;
  logic [95:0] pin_out;
  logic        irq_o, wake_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NUM_BANKS(NB), .BANK_WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .irq_o(irq_o), .wake_o(wake_o)
  );

  // behavioural reference model
  logic [31:0] m_s1[NB], m_s2[NB], m_prev[NB], m_ev[NB];
  logic [31:0] m_out[NB], m_mask[NB], m_stat[NB], m_pol[NB], m_both[NB], m_lvl[NB];
  logic [31:0] m_rd, rd_n, clr;
  logic        m_irq, irq_n;
  int          bi, off;

  always @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NB; b++) begin
        m_s1[b] = 0; m_s2[b] = 0; m_prev[b] = 0; m_out[b] = 0; m_mask[b] = 0;
        m_stat[b] = 0; m_pol[b] = 0; m_both[b] = 0; m_lvl[b] = 0;
      end
      m_rd = 0; m_irq = 0;
    end else begin
      irq_n = 0;
      for (int b = 0; b < NB; b++) if ((m_stat[b] & m_mask[b]) != 0) irq_n = 1;
      bi = int'(reg_addr) / 32;
      off = (int'(reg_addr) % 32) / 4;
      rd_n = 0;
      if (bi < NB) begin
        case (off)
          0: rd_n = m_out[bi];
          1: rd_n = m_mask[bi];
          2: rd_n = m_stat[bi];
          3: rd_n = m_pol[bi];
          4: rd_n = m_both[bi];
          5: rd_n = m_lvl[bi];
          default: rd_n = 0;
        endcase
      end
      for (int b = 0; b < NB; b++) begin
        for (int i = 0; i < 32; i++) begin
          logic c, p;
          c = m_s2[b][i]; p = m_prev[b][i];
          if (i >= W)            m_ev[b][i] = 0;
          else if (m_lvl[b][i])  m_ev[b][i] = c;
          else if (m_both[b][i]) m_ev[b][i] = c != p;
          else if (m_pol[b][i])  m_ev[b][i] = c && !p;
          else                   m_ev[b][i] = !c && p;
        end
        clr = 0;
        if (reg_wr && bi == b) begin
          case (off)
            0: m_out[b] = reg_wdata;
            1: m_mask[b] = reg_wdata;
            2: clr = reg_wdata;
            3: m_pol[b] = reg_wdata;
            4: m_both[b] = reg_wdata;
            5: m_lvl[b] = reg_wdata;
            default: ;
          endcase
        end
        m_stat[b] = (m_stat[b] & ~clr) | m_ev[b];
        m_prev[b] = m_s2[b];
        m_s2[b] = m_s1[b];
        m_s1[b] = pin_in[b*32 +: 32];
      end
      m_irq = irq_n;
      m_rd = rd_n;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int b = 0; b < NB; b++) chk("R2 drive", pin_out[b*32 +: 32], m_out[b]);
      chk("R9 irq", 32'(irq_o), 32'(m_irq));
      chk("R10 wake", 32'(wake_o), 32'(m_irq));
      chk("R1 rdata", reg_rdata, m_rd);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 7'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 7'(a);
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // reset state
    chk("R9 irq after reset", 32'(irq_o), 0);
    rd_chk(32'h04, 0, "R9 mask reset");
    rd_chk(32'h18, 0, "R1 unused offset");
    rd_chk(32'h68, 0, "R1 absent bank");
    // output drive
    wr(32'h20, 32'hA5A5_0F0F);
    chk("R2 pin_out bank1", pin_out[63:32], 32'hA5A5_0F0F);
    rd_chk(32'h20, 32'hA5A5_0F0F, "R1 readback");
    // polarity select
    wr(32'h0C, 32'h1);
    pin_in[0] = 1'b1; wait_cyc(4);
    rd_chk(32'h08, 32'h1, "R3 rising pin0");
    pin_in[1] = 1'b1; wait_cyc(4);
    rd_chk(32'h08, 32'h1, "R3 rise ignored on falling pin");
    pin_in[1] = 1'b0; pin_in[0] = 1'b0; wait_cyc(4);
    rd_chk(32'h08, 32'h3, "R3 falling pin1 only");
    // write-1-to-clear
    wr(32'h08, 32'h0);
    rd_chk(32'h08, 32'h3, "R6 zero write keeps");
    wr(32'h08, 32'h1);
    rd_chk(32'h08, 32'h2, "R6 one clears");
    // mask and combined request
    wr(32'h04, 32'h2);
    wait_cyc(1);
    chk("R9 irq raised", 32'(irq_o), 1);
    chk("R10 wake raised", 32'(wake_o), 1);
    wr(32'h08, 32'h2);
    wait_cyc(1);
    chk("R9 irq dropped", 32'(irq_o), 0);
    wr(32'h04, 32'h0);
    // both edges on bank2 pin3, polarity set to rising
    wr(32'h4C, 32'h8);
    wr(32'h50, 32'h8);
    pin_in[67] = 1'b1; wait_cyc(4);
    rd_chk(32'h48, 32'h8, "R4 rise");
    wr(32'h48, 32'h8);
    rd_chk(32'h48, 32'h0, "R6 cleared");
    pin_in[67] = 1'b0; wait_cyc(4);
    rd_chk(32'h48, 32'h8, "R4 fall despite rising polarity");
    wr(32'h48, 32'h8);
    // level on bank1 pin5
    wr(32'h34, 32'h20);
    pin_in[37] = 1'b1; wait_cyc(4);
    rd_chk(32'h28, 32'h20, "R5 level high");
    wr(32'h28, 32'h20);
    rd_chk(32'h28, 32'h20, "R7 event beats clear");
    pin_in[37] = 1'b0; wait_cyc(4);
    wr(32'h28, 32'h20);
    rd_chk(32'h28, 32'h0, "R5 level low clears");
    wr(32'h34, 32'h0);
    // pins above width
    wr(32'h10, 32'hFFFF_FFFF);
    wr(32'h04, 32'hFFFF_FFFF);
    pin_in[30] = 1'b1; pin_in[31] = 1'b1; wait_cyc(4);
    rd_chk(32'h08, 32'h0, "R8 high pins rise");
    chk("R8 no irq", 32'(irq_o), 0);
    pin_in[30] = 1'b0; pin_in[31] = 1'b0; wait_cyc(4);
    rd_chk(32'h08, 32'h0, "R8 high pins fall");
    wr(32'h10, 32'h0);
    wr(32'h04, 32'h0);
    // latency
    wr(32'h0C, 32'h5);
    wr(32'h04, 32'h4);
    @(negedge clk) pin_in[2] = 1'b1;
    wait_cyc(3);
    chk("R11 irq not yet", 32'(irq_o), 0);
    wait_cyc(1);
    chk("R11 irq on fourth edge", 32'(irq_o), 1);
    wr(32'h08, 32'h4);
    // random traffic against the model, incl. clear/event collisions (R7)
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      pin_in = pin_in ^ ({$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom}
                         & {$urandom, $urandom, $urandom});
      if ($urandom % 3 == 0) begin
        reg_wr = 1'b1;
        reg_addr = 7'(($urandom % 3) * 32 + ($urandom % 7) * 4);
        reg_wdata = $urandom;
      end else begin
        reg_wr = 1'b0;
        reg_addr = 7'($urandom % 104);
      end
    end
    @(negedge clk) reg_wr = 1'b0;
    wait_cyc(6);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule